// File: doc/BRIEF.md
# Mixed-Page-Size Translation Cache

This block is a small, fully associative cache of address translations that sits in front of a page table walker. Each entry holds one mapping of a 4 KB, 64 KB or 1 MB page. A lookup is answered in the same cycle: the block compares the probe address against every valid entry, using only the address bits above that entry's own page offset. It then returns a hit and the physical address, which is the entry's frame bits joined with the probe's offset bits.

Results from the walker are written in as refills. A refill goes into a free slot if there is one; otherwise it evicts the least recently used entry. Software-driven maintenance arrives as two strobes. One clears every entry. The other takes a 4 KB-aligned address and removes each entry, of whatever size, whose page contains that address. When two or more valid entries match one lookup, the block does not pick one. It raises a multi-hit fault instead, on a read flag or a write flag according to the direction of the lookup.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses with a zero physical address and no multi-hit flag.
- R2: The page size code is 0 for 4 KB, 1 for 64 KB and 2 for 1 MB, and an entry compares probe bits from the top down to bit 12, 16 or 20 respectively. Code 3 is reserved and behaves as 4 KB.
- R3: When exactly one valid entry matches a valid lookup, `lk_hit` is high in the same cycle. `lk_pa` is then the entry's physical address above the page offset, combined with the probe's offset bits. Stored physical bits inside the offset are ignored. `lk_pa` is zero whenever `lk_hit` is low.
- R4: When two or more valid entries match a valid lookup, `lk_hit` is low and `lk_pa` is zero. `mhit_rd` is raised if `lk_wr` is 0, and `mhit_wr` is raised if `lk_wr` is 1.
- R5: A refill writes the lowest-indexed invalid entry if one exists, otherwise the least recently used entry. The new mapping is visible to lookups from the next cycle.
- R6: A refill and a single-hit lookup each make the touched entry the most recently used. Misses and multi-hit lookups leave the order unchanged.
- R7: `inv_all` makes every entry invalid from the next cycle, including an entry refilled in the same cycle.
- R8: `inv_one_vld` removes every valid entry, of any page size, whose page contains `inv_va`. Entries that do not contain `inv_va` are untouched.
- R9: If an address invalidate arrives in the same cycle as a refill whose page contains `inv_va`, the refilled entry is left invalid. A refill whose page does not contain `inv_va` completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vld | input | 1 | Lookup request this cycle |
| lk_wr | input | 1 | Lookup direction, 1 for write and 0 for read |
| lk_va | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Exactly one entry matched |
| lk_pa | output | PA_W | Translated physical address |
| mhit_rd | output | 1 | Multi-hit on a read lookup |
| mhit_wr | output | 1 | Multi-hit on a write lookup |
| fill_vld | input | 1 | Refill strobe |
| fill_va | input | VA_W | Refill virtual address |
| fill_size | input | 2 | Refill page size code |
| fill_pa | input | PA_W | Refill physical address |
| inv_all | input | 1 | Invalidate every entry |
| inv_one_vld | input | 1 | Invalidate entries covering `inv_va` |
| inv_va | input | VA_W | 4 KB-aligned invalidate address |

## Verification
The bench builds the block with ENTRIES = 4 and 32-bit virtual and physical addresses. With four entries, the free list runs out after four refills, so the next refill lands on the least recently used slot. The eviction order, after a mix of refills and hits, can then be worked out by hand and confirmed through a lookup that misses. The small depth also lets one 1 MB entry and one 4 KB entry overlap, which produces a multi-hit in both directions. A single invalidate then removes both overlapping entries at once.

// File: rtl/xc_pkg.sv
package xc_pkg;

  typedef enum logic [1:0] {
    PG_4K   = 2'd0,
    PG_64K  = 2'd1,
    PG_1M   = 2'd2,
    PG_RSVD = 2'd3
  } pg_size_e;

  localparam int unsigned SHIFT_4K  = 12;
  localparam int unsigned SHIFT_64K = 16;
  localparam int unsigned SHIFT_1M  = 20;

  // Number of offset bits of a page of the given size code.
  function automatic int unsigned pg_shift(input logic [1:0] sz);
    case (pg_size_e'(sz))
      PG_64K:  return SHIFT_64K;
      PG_1M:   return SHIFT_1M;
      default: return SHIFT_4K;
    endcase
  endfunction

endpackage

// File: rtl/xc_match.sv
// One tag comparator: does the page described by (tag_va, size) contain probe_va?
module xc_match #(
  parameter int VA_W = 32
) (
  input  logic            en,
  input  logic [VA_W-1:0] tag_va,
  input  logic [1:0]      size,
  input  logic [VA_W-1:0] probe_va,
  output logic            match
);
  import xc_pkg::*;

  function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
    return {VA_W{1'b1}} << pg_shift(sz);
  endfunction

  assign match = en && (((tag_va ^ probe_va) & page_mask(size)) == '0);

endmodule

// File: rtl/xc_lru.sv
// Age-counter replacement order: age 0 is most recent, age ENTRIES-1 is the victim.
module xc_lru #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_vld,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] lru_idx
);
  localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0]   age_q [ENTRIES];
  logic [ENTRIES-1:0] at_max;
  logic [ENTRIES-1:0] at_zero;
  logic [ENTRIES-1:0] touch_oh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_vld) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)           age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_flags
    assign at_max[g]   = (age_q[g] == AGE_MAX);
    assign at_zero[g]  = (age_q[g] == '0);
    assign touch_oh[g] = touch_vld && (touch_idx == IDX_W'(g));
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (at_max[i]) lru_idx = IDX_W'(i);
  end

  // R6
  lru_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(at_max));

  // R6
  touch_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_vld |=> (at_zero == $past(touch_oh)));

endmodule

// File: rtl/xc_pick.sv
// Refill slot selection: lowest free entry, else the replacement victim.
module xc_pick #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid,
  input  logic [IDX_W-1:0]   lru_idx,
  output logic [IDX_W-1:0]   victim_idx,
  output logic [ENTRIES-1:0] victim_oh
);
  logic found;

  always_comb begin
    victim_idx = lru_idx;
    found      = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid[i] && !found) begin
        victim_idx = IDX_W'(i);
        found      = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_oh
    assign victim_oh[g] = (victim_idx == IDX_W'(g));
  end

  // R5
  pick_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~&valid) |-> ((valid & victim_oh) == '0));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_vld,
  input  logic            lk_wr,
  input  logic [VA_W-1:0] lk_va,
  output logic            lk_hit,
  output logic [PA_W-1:0] lk_pa,
  output logic            mhit_rd,
  output logic            mhit_wr,
  input  logic            fill_vld,
  input  logic [VA_W-1:0] fill_va,
  input  logic [1:0]      fill_size,
  input  logic [PA_W-1:0] fill_pa,
  input  logic            inv_all,
  input  logic            inv_one_vld,
  input  logic [VA_W-1:0] inv_va
);
  import xc_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(ENTRIES + 1);

  // Entry storage
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [VA_W-1:0]    tag_q  [ENTRIES];
  logic [PA_W-1:0]    pa_q   [ENTRIES];
  logic [1:0]         size_q [ENTRIES];

  // Named internal events
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] inv_match;
  logic [PA_W-1:0]    ent_pa [ENTRIES];
  logic [PA_W-1:0]    pa_or;
  logic [CNT_W-1:0]   nmatch;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   lru_idx;
  logic [IDX_W-1:0]   victim_idx;
  logic [ENTRIES-1:0] victim_oh;
  logic               fill_killed;
  logic               fill_live;
  logic               touch_vld;
  logic [IDX_W-1:0]   touch_idx;

  // Physical address: frame bits from the entry, offset bits from the probe.
  function automatic logic [PA_W-1:0] merge_pa(input logic [PA_W-1:0] base,
                                               input logic [VA_W-1:0] va,
                                               input logic [1:0]      sz);
    logic [PA_W-1:0] off_mask;
    off_mask = ~({PA_W{1'b1}} << pg_shift(sz));
    return (base & ~off_mask) | (PA_W'(va) & off_mask);
  endfunction

  function automatic logic [IDX_W-1:0] enc_idx(input logic [ENTRIES-1:0] vec);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (vec[i]) r = IDX_W'(i);
    return r;
  endfunction

  // Per-entry comparators
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    xc_match #(.VA_W(VA_W)) u_lk (
      .en       (valid_q[g]),
      .tag_va   (tag_q[g]),
      .size     (size_q[g]),
      .probe_va (lk_va),
      .match    (lk_match[g])
    );

    xc_match #(.VA_W(VA_W)) u_inv (
      .en       (valid_q[g] && inv_one_vld),
      .tag_va   (tag_q[g]),
      .size     (size_q[g]),
      .probe_va (inv_va),
      .match    (inv_match[g])
    );

    assign ent_pa[g] = lk_match[g] ? merge_pa(pa_q[g], lk_va, size_q[g]) : '0;
  end

  // Does the incoming refill's own page contain the invalidate address?
  xc_match #(.VA_W(VA_W)) u_kill (
    .en       (fill_vld && inv_one_vld),
    .tag_va   (fill_va),
    .size     (fill_size),
    .probe_va (inv_va),
    .match    (fill_killed)
  );

  // Lookup result
  always_comb begin
    pa_or = '0;
    for (int i = 0; i < ENTRIES; i++) pa_or = pa_or | ent_pa[i];
  end

  assign nmatch  = CNT_W'($countones(lk_match));
  assign hit_idx = enc_idx(lk_match);
  assign lk_hit  = lk_vld && (nmatch == CNT_W'(1));
  assign lk_pa   = lk_hit ? pa_or : '0;
  assign mhit_rd = lk_vld && !lk_wr && (nmatch > CNT_W'(1));
  assign mhit_wr = lk_vld &&  lk_wr && (nmatch > CNT_W'(1));

  // Replacement
  assign fill_live = fill_vld && !inv_all && !fill_killed;
  assign touch_vld = fill_live || lk_hit;
  assign touch_idx = fill_live ? victim_idx : hit_idx;

  xc_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_vld (touch_vld),
    .touch_idx (touch_idx),
    .lru_idx   (lru_idx)
  );

  xc_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (valid_q),
    .lru_idx    (lru_idx),
    .victim_idx (victim_idx),
    .victim_oh  (victim_oh)
  );

  // Next valid vector: address invalidate, then refill, then full clear.
  always_comb begin
    valid_d = valid_q & ~inv_match;
    if (fill_vld) valid_d = (valid_d & ~victim_oh) | (fill_killed ? '0 : victim_oh);
    if (inv_all)  valid_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_vld) begin
      tag_q[victim_idx]  <= fill_va;
      pa_q[victim_idx]   <= fill_pa;
      size_q[victim_idx] <= fill_size;
    end
  end

  // R3
  hit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $onehot(lk_match));

  // R4
  mhit_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mhit_rd || mhit_wr) |-> (!lk_hit && lk_pa == '0));

  // R5
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_live |=> ((valid_q & $past(victim_oh)) != '0));

  // R7
  inv_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0));

  // R8
  inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_one_vld && !fill_vld) |=> ((valid_q & $past(inv_match)) == '0));

  // R9
  fill_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_vld && fill_killed) |=> ((valid_q & $past(victim_oh)) == '0));

endmodule

// File: tb/xlat_cache_tb.sv
`timescale 1ns/1ps
module xlat_cache_tb;
  localparam int ENTRIES = 4;
  localparam int VA_W    = 32;
  localparam int PA_W    = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            lk_vld = 1'b0, lk_wr = 1'b0;
  logic [VA_W-1:0] lk_va = '0;
  logic            lk_hit, mhit_rd, mhit_wr;
  logic [PA_W-1:0] lk_pa;
  logic            fill_vld = 1'b0;
  logic [VA_W-1:0] fill_va = '0;
  logic [1:0]      fill_size = '0;
  logic [PA_W-1:0] fill_pa = '0;
  logic            inv_all = 1'b0, inv_one_vld = 1'b0;
  logic [VA_W-1:0] inv_va = '0;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic            hit;
    logic [PA_W-1:0] pa;
    logic            mrd;
    logic            mwr;
    string           req;
  } exp_t;

  exp_t exp_q[$];

  always #2 clk = ~clk;

  xlat_cache #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_vld(lk_vld), .lk_wr(lk_wr), .lk_va(lk_va),
    .lk_hit(lk_hit), .lk_pa(lk_pa), .mhit_rd(mhit_rd), .mhit_wr(mhit_wr),
    .fill_vld(fill_vld), .fill_va(fill_va), .fill_size(fill_size), .fill_pa(fill_pa),
    .inv_all(inv_all), .inv_one_vld(inv_one_vld), .inv_va(inv_va)
  );

  task automatic clear_inputs();
    lk_vld = 1'b0; lk_wr = 1'b0; lk_va = '0;
    fill_vld = 1'b0; fill_va = '0; fill_size = '0; fill_pa = '0;
    inv_all = 1'b0; inv_one_vld = 1'b0; inv_va = '0;
  endtask

  task automatic lookup(input logic [VA_W-1:0] va, input logic wr,
                        input logic ehit, input logic [PA_W-1:0] epa,
                        input logic emrd, input logic emwr, input string req);
    exp_t e;
    @(negedge clk);
    clear_inputs();
    lk_vld = 1'b1; lk_wr = wr; lk_va = va;
    e.hit = ehit; e.pa = epa; e.mrd = emrd; e.mwr = emwr; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic fill(input logic [VA_W-1:0] va, input logic [1:0] sz,
                      input logic [PA_W-1:0] pa, input logic iall,
                      input logic ione, input logic [VA_W-1:0] iva);
    @(negedge clk);
    clear_inputs();
    fill_vld = 1'b1; fill_va = va; fill_size = sz; fill_pa = pa;
    inv_all = iall; inv_one_vld = ione; inv_va = iva;
  endtask

  task automatic inval(input logic iall, input logic [VA_W-1:0] iva);
    @(negedge clk);
    clear_inputs();
    inv_all = iall; inv_one_vld = !iall; inv_va = iva;
  endtask

  task automatic idle();
    @(negedge clk);
    clear_inputs();
  endtask

  // Monitor: compares every lookup just before the edge that follows it.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (lk_vld) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL unexpected lookup: hit=%0b pa=%h", lk_hit, lk_pa);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (lk_hit !== e.hit || lk_pa !== e.pa || mhit_rd !== e.mrd || mhit_wr !== e.mwr) begin
            errors++;
            $display("FAIL %s va=%h: got hit=%0b pa=%h mrd=%0b mwr=%0b, expected hit=%0b pa=%h mrd=%0b mwr=%0b",
                     e.req, lk_va, lk_hit, lk_pa, mhit_rd, mhit_wr, e.hit, e.pa, e.mrd, e.mwr);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: lookup while in reset and right after release
    lookup(32'h0012_3000, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R1 in reset");
    idle();
    rst_n = 1'b1;
    lookup(32'h0012_3000, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R1 after reset");

    // R3/R5: fill three sizes into free slots, hit and miss each
    fill(32'h0012_3000, 2'd0, 32'h8000_0000, 1'b0, 1'b0, '0);
    lookup(32'h0012_3ABC, 1'b0, 1'b1, 32'h8000_0ABC, 1'b0, 1'b0, "R3 4K hit");
    lookup(32'h0012_4000, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R2 4K boundary miss");
    fill(32'h0045_0000, 2'd1, 32'h9001_0000, 1'b0, 1'b0, '0);
    lookup(32'h0045_ABCD, 1'b1, 1'b1, 32'h9001_ABCD, 1'b0, 1'b0, "R2 64K hit");
    lookup(32'h0046_0000, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R2 64K boundary miss");
    fill(32'h0300_0123, 2'd2, 32'hA012_3456, 1'b0, 1'b0, '0);
    lookup(32'h030F_FFFF, 1'b0, 1'b1, 32'hA01F_FFFF, 1'b0, 1'b0, "R3 1M hit offset masking");
    lookup(32'h0310_0000, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R2 1M boundary miss");

    // R4: overlapping 4K inside the 1M page
    fill(32'h0305_0000, 2'd0, 32'hB000_0000, 1'b0, 1'b0, '0);
    lookup(32'h0305_0010, 1'b0, 1'b0, '0, 1'b1, 1'b0, "R4 read multi-hit");
    lookup(32'h0305_0010, 1'b1, 1'b0, '0, 1'b0, 1'b1, "R4 write multi-hit");
    lookup(32'h0306_0000, 1'b0, 1'b1, 32'hA016_0000, 1'b0, 1'b0, "R3 1M single hit");

    // R6: touch the 4K entry so the 64K entry becomes least recently used
    lookup(32'h0012_3000, 1'b0, 1'b1, 32'h8000_0000, 1'b0, 1'b0, "R6 touch");
    fill(32'h0777_7000, 2'd0, 32'hC000_0000, 1'b0, 1'b0, '0);
    lookup(32'h0045_0000, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R6 LRU entry evicted");
    lookup(32'h0012_3000, 1'b0, 1'b1, 32'h8000_0000, 1'b0, 1'b0, "R5 recent entry kept");
    lookup(32'h0777_7123, 1'b1, 1'b1, 32'hC000_0123, 1'b0, 1'b0, "R5 refill in LRU slot");

    // R8: one address removes the 1M and the 4K entry that cover it
    inval(1'b0, 32'h0305_0000);
    lookup(32'h0305_0010, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R8 overlapping entries removed");
    lookup(32'h0300_0000, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R8 1M entry removed");
    lookup(32'h0012_3004, 1'b0, 1'b1, 32'h8000_0004, 1'b0, 1'b0, "R8 other entry untouched");

    // R9: coinciding invalidate inside refill page, then one outside it
    fill(32'h0050_0000, 2'd1, 32'hD000_0000, 1'b0, 1'b1, 32'h0050_F000);
    lookup(32'h0050_0000, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R9 refill killed");
    fill(32'h0060_0000, 2'd0, 32'hF000_0000, 1'b0, 1'b1, 32'h0061_0000);
    lookup(32'h0060_0ABC, 1'b0, 1'b1, 32'hF000_0ABC, 1'b0, 1'b0, "R9 refill kept");

    // R7: full clear, and a refill alongside it
    inval(1'b1, '0);
    lookup(32'h0012_3000, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R7 cleared");
    lookup(32'h0060_0000, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R7 cleared");
    fill(32'h0200_0000, 2'd2, 32'h1000_0000, 1'b1, 1'b0, '0);
    lookup(32'h0200_0000, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R7 concurrent refill dropped");

    // R2: reserved code behaves as 4K
    fill(32'h0123_4000, 2'd3, 32'hE000_0000, 1'b0, 1'b0, '0);
    lookup(32'h0123_4FFF, 1'b0, 1'b1, 32'hE000_0FFF, 1'b0, 1'b0, "R2 reserved size hit");
    lookup(32'h0123_5000, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R2 reserved size as 4K");

    idle();
    idle();
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: %0d lookups unchecked, expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule